// File: doc/BRIEF.md
# Windowed communication watchdog timer

This block checks that a host controller keeps writing to the device's registers. It divides the system clock into slow ticks and counts the ticks since the host last restarted it. If the count reaches the programmed upper limit before a restart arrives, it raises a watchdog fault. The active-low alarm output is driven low and a sticky fault status bit is set.

The lower-limit code selects one of two modes. With a code of 2'b00 the block is a plain timeout. A register write strobe from either host interface restarts the count. With any other code the block is a window comparator. Only a write flagged as targeting the watchdog register restarts it. Such a write that arrives before the lower limit is a fault, and so is reaching the upper limit. Other writes are ignored in this mode.

A fault latches a watchdog condition. The condition holds the alarm low until the enable bit is dropped or the block is reset. The status bit stays set after that. It clears only when the alarm status register is read while the condition is already clear. All control and status pins are plain levels or one-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `comm_watchdog`

## Requirements
- R1: After a hardware reset, alarm_n is 1 and fault_sticky is 0.
- R2: While wd_enable is 0, the tick and count are held at zero and no fault is raised. A cycle that samples wd_enable at 0 clears the watchdog condition, so alarm_n is 1 after that edge.
- R3: One tick occurs every TICK_DIV clocks while enabled. Upper codes 2'b00, 2'b01, 2'b10 and 2'b11 select 16, 64, 256 and 1024 ticks. Take the edge that first samples wd_enable at 1 as edge 1, with no writes after it. Then alarm_n is still 1 after edge U*TICK_DIV and is 0 after edge U*TICK_DIV+1.
- R4: In timeout mode (lower code 2'b00), a write strobe on wr_strobe_a or wr_strobe_b restarts both the tick divider and the count.
- R5: In window mode, lower codes 2'b01, 2'b10 and 2'b11 select 1, 4 and 16 ticks. A write with wr_is_wdreg at 1 is a fault if the count is below the lower limit. The fault appears at the same edge that samples the write.
- R6: In window mode, a watchdog-register write at or after the lower limit restarts the count. A write with wr_is_wdreg at 0 has no effect.
- R7: In window mode, reaching the upper limit with no restarting write raises a fault.
- R8: On a fault, alarm_n goes to 0 and fault_sticky goes to 1. alarm_n stays 0 until the condition is cleared, whether or not the status is read.
- R9: A status_rd strobe while the condition is active leaves fault_sticky at 1. A status_rd strobe once the condition is clear sets it to 0.
- R10: soft_rst synchronously clears the condition, the status bit, the divider and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset strobe |
| wd_enable | input | 1 | Watchdog enable bit |
| up_code | input | 2 | Upper-limit code |
| lo_code | input | 2 | Lower-limit code; 2'b00 selects timeout mode |
| wr_strobe_a | input | 1 | Register write strobe, first host interface |
| wr_strobe_b | input | 1 | Register write strobe, second host interface |
| wr_is_wdreg | input | 1 | Current write targets the watchdog register |
| status_rd | input | 1 | Read strobe of the alarm status register |
| alarm_n | output | 1 | Active-low alarm |
| fault_sticky | output | 1 | Sticky watchdog fault status bit |

## Verification
A vector table sweeps the main function. It pairs upper and lower codes with the delay from enable to one write. The write is either a plain write or a watchdog-register write, on either interface. Early, in-window and late writes in window mode separate the lower-limit compare from the upper-limit timeout. Plain writes in window mode show they are ignored. Directed runs cover four further cases:
- the exact expiry edge;
- periodic restarts from each interface;
- the read-before-clear and read-after-clear order of the sticky bit;
- software reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned MAX_UP_TICKS = 1024;

  // Upper codes: 16, 64, 256, 1024 ticks.
  function automatic int unsigned up_ticks(input logic [1:0] code);
    return 32'd16 << (2 * code);
  endfunction

  // Lower codes: 0 (timeout mode), 1, 4, 16 ticks.
  function automatic int unsigned lo_ticks(input logic [1:0] code);
    if (code == 2'b00) return 32'd0;
    return 32'd1 << (2 * (code - 2'd1));
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase;

  assign tick = !clr && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= '0;
    else if (clr)          phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (tick && !(&count))    count <= count + 1'b1;
  end
endmodule

// File: rtl/wdt_window_judge.sv
module wdt_window_judge #(
  parameter int unsigned W = 11
) (
  input  logic         enable,
  input  logic [1:0]   up_code,
  input  logic [1:0]   lo_code,
  input  logic         wr_any,
  input  logic         wr_wd,
  input  logic [W-1:0] count,
  output logic         restart,
  output logic         fault_evt
);
  logic [W-1:0] up_lim;
  logic [W-1:0] lo_lim;
  logic         win_mode;
  logic         late;
  logic         early;

  assign up_lim   = W'(wdt_pkg::up_ticks(up_code));
  assign lo_lim   = W'(wdt_pkg::lo_ticks(lo_code));
  assign win_mode = (lo_code != 2'b00);

  assign late  = enable && (count >= up_lim);
  assign early = enable && win_mode && wr_wd && (count < lo_lim);

  assign fault_evt = late || early;
  assign restart   = enable && (win_mode ? wr_wd : wr_any);
endmodule

// File: rtl/wdt_fault_hold.sv
module wdt_fault_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic enable,
  input  logic fault_evt,
  input  logic status_rd,
  output logic cond,
  output logic sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond   <= 1'b0;
      sticky <= 1'b0;
    end else if (soft_rst) begin
      cond   <= 1'b0;
      sticky <= 1'b0;
    end else begin
      if (!enable)        cond <= 1'b0;
      else if (fault_evt) cond <= 1'b1;

      if (fault_evt)                sticky <= 1'b1;
      else if (status_rd && !cond)  sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/comm_watchdog.sv
module comm_watchdog #(
  parameter int unsigned TICK_DIV = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       wd_enable,
  input  logic [1:0] up_code,
  input  logic [1:0] lo_code,
  input  logic       wr_strobe_a,
  input  logic       wr_strobe_b,
  input  logic       wr_is_wdreg,
  input  logic       status_rd,
  output logic       alarm_n,
  output logic       fault_sticky
);
  localparam int unsigned CNT_W = $clog2(wdt_pkg::MAX_UP_TICKS) + 1;

  logic             wr_any;
  logic             wr_wd;
  logic             restart;
  logic             fault_evt;
  logic             hold_clr;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic             cond;

  assign wr_any   = wr_strobe_a || wr_strobe_b;
  assign wr_wd    = wr_any && wr_is_wdreg;
  assign hold_clr = !wd_enable || soft_rst || restart;

  wdt_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (hold_clr),
    .tick (tick)
  );

  wdt_tick_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (hold_clr),
    .tick (tick),
    .count(count)
  );

  wdt_window_judge #(.W(CNT_W)) u_judge (
    .enable   (wd_enable && !soft_rst),
    .up_code  (up_code),
    .lo_code  (lo_code),
    .wr_any   (wr_any),
    .wr_wd    (wr_wd),
    .count    (count),
    .restart  (restart),
    .fault_evt(fault_evt)
  );

  wdt_fault_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .enable   (wd_enable),
    .fault_evt(fault_evt),
    .status_rd(status_rd),
    .cond     (cond),
    .sticky   (fault_sticky)
  );

  assign alarm_n = !cond;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic wd_enable,
  input logic status_rd,
  input logic alarm_n,
  input logic fault_sticky
);
  assert_alarm_has_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> fault_sticky);

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> alarm_n);

  assert_alarm_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_n) |-> $past(wd_enable));

  assert_sticky_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_sticky) |-> ($past(status_rd) || $past(soft_rst)));

  assert_read_while_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !alarm_n && !soft_rst) |=> fault_sticky);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (alarm_n && !fault_sticky));
endmodule

bind comm_watchdog wdt_checker u_wdt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .wd_enable   (wd_enable),
  .status_rd   (status_rd),
  .alarm_n     (alarm_n),
  .fault_sticky(fault_sticky)
);

// File: tb/test_comm_watchdog.sv
module test_comm_watchdog;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DIV = 4;

  typedef struct packed {
    logic [1:0]  up;
    logic [1:0]  lo;
    logic [15:0] waitc;
    logic        use_b;
    logic        wdreg;
    logic        exp_fault;
  } vec_t;

  // Delays are edges from enable to the write, with DIV = 4.
  localparam vec_t VEC [10] = '{
    '{2'd0, 2'd0, 16'd40,  1'b0, 1'b0, 1'b0},  // timeout, in time
    '{2'd0, 2'd0, 16'd70,  1'b0, 1'b0, 1'b1},  // timeout, late
    '{2'd1, 2'd0, 16'd100, 1'b1, 1'b0, 1'b0},  // longer limit, iface b
    '{2'd0, 2'd1, 16'd2,   1'b0, 1'b1, 1'b1},  // window 1 tick, early
    '{2'd0, 2'd1, 16'd10,  1'b0, 1'b1, 1'b0},  // window 1 tick, ok
    '{2'd0, 2'd2, 16'd10,  1'b1, 1'b1, 1'b1},  // window 4 ticks, early
    '{2'd0, 2'd2, 16'd30,  1'b0, 1'b1, 1'b0},  // window 4 ticks, ok
    '{2'd0, 2'd1, 16'd70,  1'b0, 1'b1, 1'b1},  // window, late
    '{2'd0, 2'd1, 16'd2,   1'b0, 1'b0, 1'b0},  // window, plain write ignored
    '{2'd1, 2'd3, 16'd60,  1'b1, 1'b1, 1'b1}   // window 16 ticks, early
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       wd_enable = 1'b0;
  logic [1:0] up_code = 2'd0;
  logic [1:0] lo_code = 2'd0;
  logic       wr_strobe_a = 1'b0;
  logic       wr_strobe_b = 1'b0;
  logic       wr_is_wdreg = 1'b0;
  logic       status_rd = 1'b0;
  logic       alarm_n;
  logic       fault_sticky;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  comm_watchdog #(.TICK_DIV(DIV)) i_comm_watchdog (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wd_enable(wd_enable),
    .up_code(up_code), .lo_code(lo_code), .wr_strobe_a(wr_strobe_a),
    .wr_strobe_b(wr_strobe_b), .wr_is_wdreg(wr_is_wdreg),
    .status_rd(status_rd), .alarm_n(alarm_n), .fault_sticky(fault_sticky)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_pulse(input logic use_b, input logic wdreg);
    wr_strobe_a = !use_b;
    wr_strobe_b = use_b;
    wr_is_wdreg = wdreg;
    step(1);
    wr_strobe_a = 1'b0;
    wr_strobe_b = 1'b0;
    wr_is_wdreg = 1'b0;
  endtask

  task automatic clear_all();
    wd_enable = 1'b0;
    step(1);
    status_rd = 1'b1;
    step(1);
    status_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    check("R1 alarm_n at reset", alarm_n, 1'b1);
    check("R1 sticky at reset", fault_sticky, 1'b0);
    rst_n = 1'b1;
    step(2);
    check("R1 alarm_n after reset", alarm_n, 1'b1);

    // Disabled: long idle raises nothing
    step(200);
    check("R2 disabled idle alarm", alarm_n, 1'b1);
    check("R2 disabled idle sticky", fault_sticky, 1'b0);

    // Vector table
    for (int i = 0; i < 10; i++) begin
      clear_all();
      up_code   = VEC[i].up;
      lo_code   = VEC[i].lo;
      wd_enable = 1'b1;
      step(int'(VEC[i].waitc));
      write_pulse(VEC[i].use_b, VEC[i].wdreg);
      if (VEC[i].lo == 2'd0) begin
        check("R4 table alarm", alarm_n, !VEC[i].exp_fault);
        check("R3 table sticky", fault_sticky, VEC[i].exp_fault);
      end else if (!VEC[i].wdreg) begin
        check("R6 table ignored write", alarm_n, 1'b1);
      end else if (VEC[i].waitc > 16'd64) begin
        check("R7 table late alarm", alarm_n, !VEC[i].exp_fault);
        check("R8 table sticky", fault_sticky, VEC[i].exp_fault);
      end else begin
        check("R5 table early alarm", alarm_n, !VEC[i].exp_fault);
        check("R6 table sticky", fault_sticky, VEC[i].exp_fault);
      end
    end

    // Exact expiry edge, upper code 0 = 16 ticks
    clear_all();
    up_code = 2'd0; lo_code = 2'd0;
    wd_enable = 1'b1;
    step(16 * DIV);
    check("R3 just before expiry", alarm_n, 1'b1);
    step(1);
    check("R3 at expiry", alarm_n, 1'b0);

    // Sticky order
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    check("R9 read while active keeps sticky", fault_sticky, 1'b1);
    check("R8 alarm held after read", alarm_n, 1'b0);
    step(20);
    write_pulse(1'b0, 1'b0);
    check("R8 alarm held after write", alarm_n, 1'b0);
    wd_enable = 1'b0;
    step(1);
    check("R2 disable clears alarm", alarm_n, 1'b1);
    check("R9 sticky after clear, before read", fault_sticky, 1'b1);
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    check("R9 read after clear", fault_sticky, 1'b0);

    // Periodic restarts from each interface, timeout mode
    up_code = 2'd0; lo_code = 2'd0;
    wd_enable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(50);
      write_pulse(k[0], 1'b0);
    end
    check("R4 periodic restarts a/b", alarm_n, 1'b1);

    // Periodic watchdog-register writes in window mode
    clear_all();
    up_code = 2'd0; lo_code = 2'd2;
    wd_enable = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(40);
      write_pulse(1'b1, 1'b1);
    end
    check("R6 in-window restarts", alarm_n, 1'b1);

    // Window mode: plain writes do not restart, so the upper limit expires
    clear_all();
    up_code = 2'd0; lo_code = 2'd1;
    wd_enable = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(30);
      write_pulse(1'b0, 1'b0);
    end
    check("R7 plain writes do not restart", alarm_n, 1'b0);

    // Software reset
    soft_rst = 1'b1; step(1); soft_rst = 1'b0;
    check("R10 soft reset alarm", alarm_n, 1'b1);
    check("R10 soft reset sticky", fault_sticky, 1'b0);
    step(40);
    check("R10 count restarted", alarm_n, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule